// File: doc/BRIEF.md
# Pause Frame Transmit Controller

This block decides when a 10/100 Ethernet MAC sends flow control towards its link partner. Software writes one 32-bit control register. The register holds a 16-bit pause time, two flag bits and a busy/trigger bit. A duplex-mode input selects which of two mechanisms the trigger starts.

In full duplex, setting the trigger makes the block request the transmitter. Once the request is granted, the block streams one 64-byte PAUSE control frame over a byte-wide interface, one byte per clock. An internal CRC-32 unit fills in the frame check sequence. In half duplex, the same busy bit raises a jam (backpressure) request towards the transmitter. That request holds until software clears the bit or the link moves to full duplex. While the transmitter-enable input is low, the block neither starts a frame nor asserts jam.

Top module: `pause_tx_ctrl`

## Requirements
- R1: The register reads as {pause_time[31:16], 13'b0, pass_ctrl[2], flow_en[1], busy[0]} and is all zero after reset. Bits 15:3 always read zero, and writes to them have no effect. The flow_en and pass_ctrl outputs follow bits 1 and 2.
- R2: A write with bit 0 set, made while busy is clear and tx_enable is high, sets busy. In full duplex, tx_req then rises, and the first byte appears on tx_valid/tx_data in the cycle after tx_grant is sampled high together with tx_req. No byte is sent before a grant.
- R3: Bytes 0..59 of the frame are, in order: 01 80 C2 00 00 01, then station_addr from bits 47:40 down to 7:0, then 88 08, then 00 01, then the pause time (high byte first), then zeros.
- R4: Bytes 60..63 carry the complement of the reflected CRC-32 over bytes 0..59 (polynomial EDB88320h, initial value FFFFFFFFh), least significant byte first.
- R5: The frame goes out as 64 bytes on consecutive cycles, with tx_last high only on byte 63. Busy reads clear in the cycle after the last byte, and tx_req then drops.
- R6: A trigger made in half duplex sets busy, and jam_req stays high while busy is set and tx_enable is high. No frame is sent during jam.
- R7: Half-duplex backpressure ends, with busy cleared, when software writes bit 0 as zero or when full_duplex goes high.
- R8: While tx_enable is low, a trigger write leaves busy clear, and jam_req and tx_req stay low.
- R9: A write while busy is set leaves the pause time and flag bits unchanged. Such a write cannot stop a full-duplex frame that is waiting or in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_enable | input | 1 | Transmitter enabled |
| station_addr | input | 48 | Source address placed in the frame |
| flow_en | output | 1 | Stored flow control enable flag |
| pass_ctrl | output | 1 | Stored pass-control-frames flag |
| jam_req | output | 1 | Half-duplex backpressure request |
| tx_req | output | 1 | Request for the transmitter |
| tx_grant | input | 1 | Transmitter grants the request |
| tx_valid | output | 1 | Frame byte valid |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Last byte of the frame |

## Verification
The assertions check cycle-level rules on every clock. They cover tx_last implying tx_valid, busy clearing right after the last byte, jam only while busy and with the transmitter enabled, jam and frame bytes never overlapping, a frame starting only after a granted request, and the pause time staying stable across writes made while busy. Only the bench scenarios can show the exact byte contents and FCS of frames with different pause times and addresses. The same holds for the two ways backpressure ends, for triggers being ignored while the transmitter is off, and for a mid-frame abort attempt having no effect.

// File: rtl/pause_pkg.sv
package pause_pkg;

    localparam int unsigned REG_W        = 32;
    localparam int unsigned PT_W         = 16;
    localparam int unsigned ADDR_W       = 48;
    localparam int unsigned MIN_BYTES    = 60;
    localparam int unsigned FCS_BYTES    = 4;
    localparam int unsigned FRAME_BYTES  = MIN_BYTES + FCS_BYTES;
    localparam int unsigned CNT_W        = $clog2(FRAME_BYTES);
    localparam logic [31:0] CRC_POLY     = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED     = 32'hFFFF_FFFF;

    // Register bit positions
    localparam int unsigned BIT_BUSY  = 0;
    localparam int unsigned BIT_FLOW  = 1;
    localparam int unsigned BIT_PASS  = 2;

    typedef struct packed {
        logic [PT_W-1:0] pause_time;
        logic            pass_ctrl;
        logic            flow_en;
        logic            busy;
        logic            kind_frame;   // 1: busy tracks a frame, 0: tracks jam
    } ctrl_state_t;

    typedef struct packed {
        logic       valid;
        logic       last;
        logic [7:0] data;
    } tx_beat_t;

    function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] d);
        logic [31:0] c;
        c = c_in;
        for (int b = 0; b < 8; b++) begin
            c = (c[0] ^ d[b]) ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        end
        return c;
    endfunction

    function automatic logic [7:0] body_byte(input logic [CNT_W-1:0] idx,
                                             input logic [ADDR_W-1:0] sa,
                                             input logic [PT_W-1:0] pt);
        logic [7:0] v;
        case (idx)
            CNT_W'(0):  v = 8'h01;
            CNT_W'(1):  v = 8'h80;
            CNT_W'(2):  v = 8'hC2;
            CNT_W'(3):  v = 8'h00;
            CNT_W'(4):  v = 8'h00;
            CNT_W'(5):  v = 8'h01;
            CNT_W'(6):  v = sa[47:40];
            CNT_W'(7):  v = sa[39:32];
            CNT_W'(8):  v = sa[31:24];
            CNT_W'(9):  v = sa[23:16];
            CNT_W'(10): v = sa[15:8];
            CNT_W'(11): v = sa[7:0];
            CNT_W'(12): v = 8'h88;
            CNT_W'(13): v = 8'h08;
            CNT_W'(14): v = 8'h00;
            CNT_W'(15): v = 8'h01;
            CNT_W'(16): v = pt[15:8];
            CNT_W'(17): v = pt[7:0];
            default:    v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pfc_regs.sv
module pfc_regs
    import pause_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             full_duplex,
    input  logic             tx_enable,
    input  logic             frame_done,
    output ctrl_state_t      st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (st.busy) begin
            if (st.kind_frame) begin
                if (frame_done) st.busy <= 1'b0;
            end else if (full_duplex || (wr && !wdata[BIT_BUSY])) begin
                st.busy <= 1'b0;
            end
        end else if (wr) begin
            st.pause_time <= wdata[REG_W-1 -: PT_W];
            st.pass_ctrl  <= wdata[BIT_PASS];
            st.flow_en    <= wdata[BIT_FLOW];
            if (wdata[BIT_BUSY] && tx_enable) begin
                st.busy       <= 1'b1;
                st.kind_frame <= full_duplex;
            end
        end
    end
endmodule

// File: rtl/pfc_crc32.sv
module pfc_crc32
    import pause_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        step,
    input  logic [7:0]  din,
    output logic [31:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || init) crc <= CRC_SEED;
        else if (step)   crc <= crc_step(crc, din);
    end
endmodule

// File: rtl/pfc_frame_gen.sv
module pfc_frame_gen
    import pause_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_frame,
    input  logic              tx_enable,
    input  logic              tx_grant,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic [PT_W-1:0]   pause_time,
    output logic              tx_req,
    output tx_beat_t          beat
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BYTES - 1);
    localparam logic [CNT_W-1:0] BODY_END = CNT_W'(MIN_BYTES);

    logic             sending;
    logic [CNT_W-1:0] cnt;
    logic             start;
    logic             in_body;
    logic [31:0]      crc;
    logic [31:0]      fcs;
    logic [CNT_W-1:0] fcs_off;
    logic [7:0]       body;

    assign start   = busy_frame && tx_enable && tx_grant && !sending;
    assign tx_req  = (busy_frame && tx_enable) || sending;
    assign in_body = cnt < BODY_END;

    always_ff @(posedge clk) begin
        if (rst) begin
            sending <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            sending <= 1'b1;
            cnt     <= '0;
        end else if (sending) begin
            if (cnt == LAST_IDX) sending <= 1'b0;
            else                 cnt <= cnt + 1'b1;
        end
    end

    assign body = body_byte(cnt, station_addr, pause_time);

    pfc_crc32 u_crc (
        .clk  (clk),
        .rst  (rst),
        .init (start),
        .step (sending && in_body),
        .din  (body),
        .crc  (crc)
    );

    assign fcs     = ~crc;
    assign fcs_off = cnt - BODY_END;

    always_comb begin
        beat.valid = sending;
        beat.last  = sending && (cnt == LAST_IDX);
        beat.data  = '0;
        if (sending) beat.data = in_body ? body : fcs[8*fcs_off[1:0] +: 8];
    end
endmodule

// File: rtl/pause_tx_ctrl.sv
module pause_tx_ctrl
    import pause_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              full_duplex,
    input  logic              tx_enable,
    input  logic [ADDR_W-1:0] station_addr,
    output logic              flow_en,
    output logic              pass_ctrl,
    output logic              jam_req,
    output logic              tx_req,
    input  logic              tx_grant,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last
);
    ctrl_state_t st;
    tx_beat_t    beat;

    pfc_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr          (reg_wr),
        .wdata       (reg_wdata),
        .full_duplex (full_duplex),
        .tx_enable   (tx_enable),
        .frame_done  (beat.last),
        .st          (st)
    );

    pfc_frame_gen u_gen (
        .clk          (clk),
        .rst          (rst),
        .busy_frame   (st.busy && st.kind_frame),
        .tx_enable    (tx_enable),
        .tx_grant     (tx_grant),
        .station_addr (station_addr),
        .pause_time   (st.pause_time),
        .tx_req       (tx_req),
        .beat         (beat)
    );

    always_comb begin
        reg_rdata                     = '0;
        reg_rdata[REG_W-1 -: PT_W]    = st.pause_time;
        reg_rdata[BIT_PASS]           = st.pass_ctrl;
        reg_rdata[BIT_FLOW]           = st.flow_en;
        reg_rdata[BIT_BUSY]           = st.busy;
    end

    assign flow_en   = st.flow_en;
    assign pass_ctrl = st.pass_ctrl;
    assign jam_req   = st.busy && !st.kind_frame && !full_duplex && tx_enable;
    assign tx_valid  = beat.valid;
    assign tx_data   = beat.data;
    assign tx_last   = beat.last;
endmodule

// File: rtl/pause_tx_ctrl_chk.sv
module pause_tx_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [31:0] reg_rdata,
    input logic        tx_enable,
    input logic        jam_req,
    input logic        tx_req,
    input logic        tx_grant,
    input logic        tx_valid,
    input logic        tx_last
);
    // R5
    last_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);

    // R5
    busy_clears_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        tx_last |=> !reg_rdata[0]);

    // R6
    jam_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
        jam_req |-> reg_rdata[0]);

    // R6
    no_frame_during_jam_chk: assert property (@(posedge clk) disable iff (rst)
        jam_req |-> !tx_valid);

    // R8
    jam_off_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_enable |-> !jam_req);

    // R2
    start_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> $past(tx_grant && tx_req));

    // R9
    pt_hold_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[0] && reg_wr) |=> $stable(reg_rdata[31:16]));
endmodule

bind pause_tx_ctrl pause_tx_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .tx_enable (tx_enable),
    .jam_req   (jam_req),
    .tx_req    (tx_req),
    .tx_grant  (tx_grant),
    .tx_valid  (tx_valid),
    .tx_last   (tx_last)
);

// File: tb/pause_tx_ctrl_tb.sv
module pause_tx_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        full_duplex = 1'b1;
    logic        tx_enable = 1'b1;
    logic [47:0] station_addr = 48'h0;
    logic        flow_en, pass_ctrl, jam_req, tx_req, tx_valid, tx_last;
    logic        tx_grant = 1'b0;
    logic [7:0]  tx_data;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pause_tx_ctrl u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    endtask

    task automatic reg_write(input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    function automatic logic [7:0] ref_byte(input int i, input logic [47:0] sa, input logic [15:0] pt);
        logic [7:0] hdr [18];
        hdr = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01,
                sa[47:40], sa[39:32], sa[31:24], sa[23:16], sa[15:8], sa[7:0],
                8'h88, 8'h08, 8'h00, 8'h01, pt[15:8], pt[7:0]};
        return (i < 18) ? hdr[i] : 8'h00;
    endfunction

    function automatic logic [31:0] ref_fcs(input logic [47:0] sa, input logic [15:0] pt);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 60; i++) begin
            logic [7:0] d = ref_byte(i, sa, pt);
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ d[b];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        return ~c;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset reg", reg_rdata, 32'h0);
        chk("R1 reset flags", {30'b0, flow_en, pass_ctrl}, 32'h0);
        chk("R5 reset tx", {29'b0, tx_req, tx_valid, jam_req}, 32'h0);
    endtask

    task automatic t_reserved();
        full_duplex = 1'b1;
        reg_write(32'h1234_FFFE);
        chk("R1 reserved read zero", reg_rdata, 32'h1234_0006);
        chk("R1 flag outputs", {30'b0, pass_ctrl, flow_en}, 32'h3);
        chk("R1 no trigger", {30'b0, tx_req, jam_req}, 32'h0);
    endtask

    task automatic t_frame(input logic [15:0] pt, input logic [47:0] sa);
        logic [31:0] fcs;
        logic [7:0]  exp;
        full_duplex = 1'b1; tx_enable = 1'b1; station_addr = sa;
        fcs = ref_fcs(sa, pt);
        reg_write({pt, 16'h0001});
        chk("R2 busy set", {31'b0, reg_rdata[0]}, 32'h1);
        chk("R2 tx_req", {31'b0, tx_req}, 32'h1);
        reg_write(32'hFFFF_0000);
        chk("R9 pt unchanged", {16'h0, reg_rdata[31:16]}, {16'h0, pt});
        chk("R9 busy kept", {31'b0, reg_rdata[0]}, 32'h1);
        repeat (2) @(negedge clk);
        chk("R2 no byte before grant", {31'b0, tx_valid}, 32'h0);
        tx_grant = 1'b1;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (i == 0) tx_grant = 1'b0;
            if (i == 10) begin reg_wr = 1'b1; reg_wdata = 32'h0; end
            if (i == 11) reg_wr = 1'b0;
            exp = (i < 60) ? ref_byte(i, sa, pt) : fcs[8*(i-60) +: 8];
            chk("R5 valid", {31'b0, tx_valid}, 32'h1);
            chk(i < 60 ? "R3 byte" : "R4 fcs byte", {24'h0, tx_data}, {24'h0, exp});
            chk("R5 last", {31'b0, tx_last}, {31'b0, (i == 63)});
        end
        @(negedge clk);
        chk("R5 busy clear", {31'b0, reg_rdata[0]}, 32'h0);
        chk("R5 idle", {30'b0, tx_req, tx_valid}, 32'h0);
    endtask

    task automatic t_jam();
        full_duplex = 1'b0; tx_enable = 1'b1;
        reg_write(32'h5A5A_0001);
        chk("R6 busy", {31'b0, reg_rdata[0]}, 32'h1);
        chk("R6 jam", {31'b0, jam_req}, 32'h1);
        chk("R6 no frame", {30'b0, tx_req, tx_valid}, 32'h0);
        reg_write(32'hABCD_0007);
        chk("R9 pt unchanged in jam", reg_rdata, 32'h5A5A_0001);
        chk("R6 jam held", {31'b0, jam_req}, 32'h1);
        tx_enable = 1'b0;
        @(negedge clk);
        chk("R8 jam gated", {31'b0, jam_req}, 32'h0);
        tx_enable = 1'b1;
        @(negedge clk);
        chk("R6 jam back", {31'b0, jam_req}, 32'h1);
        reg_write(32'h0);
        chk("R7 sw clear", {30'b0, reg_rdata[0], jam_req}, 32'h0);
        reg_write(32'h0000_0001);
        chk("R6 retrigger", {31'b0, jam_req}, 32'h1);
        full_duplex = 1'b1;
        @(negedge clk);
        chk("R7 fd clear", {29'b0, reg_rdata[0], jam_req, tx_req}, 32'h0);
        repeat (3) @(negedge clk);
        chk("R7 no frame after jam", {31'b0, tx_valid}, 32'h0);
    endtask

    task automatic t_disabled();
        tx_enable = 1'b0; full_duplex = 1'b1; tx_grant = 1'b1;
        reg_write(32'h7777_0001);
        repeat (3) @(negedge clk);
        chk("R8 fd ignored", {29'b0, reg_rdata[0], tx_req, tx_valid}, 32'h0);
        full_duplex = 1'b0;
        reg_write(32'h7777_0001);
        chk("R8 hd ignored", {30'b0, reg_rdata[0], jam_req}, 32'h0);
        tx_grant = 1'b0; tx_enable = 1'b1; full_duplex = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reserved();
        t_frame(16'h1234, 48'h0011_2233_4455);
        t_frame(16'hFFFF, 48'hA5C3_0F96_7E81);
        t_frame(16'h0000, 48'hFFFF_FFFF_FFFF);
        t_jam();
        t_disabled();
        t_frame(16'h8001, 48'h0200_0000_0001);
        summary();
    end
endmodule